// File: doc/BRIEF.md
# Synchronous Character Hunter with CRC

This block is the receive-side front end of a character-oriented synchronous link. Recovered serial bits arrive one per handshake. While the block is in the hunt state, it compares the most recent bits against a programmed sync pattern on every accepted bit. The pattern is either one character or two consecutive characters. As an alternative, an external strobe can declare sync. Once sync is declared, the block leaves hunt, issues a one-cycle sync pulse and cuts the following bits into fixed-width characters. These characters are offered on a valid/ready output stream.

A 16-bit CRC accumulator runs on every bit received after sync. The sync characters themselves never enter it. Software picks the polynomial (CRC-16 or CRC-CCITT) and picks whether the register starts from all ones or all zeros. When the transmitter appends its CRC (high byte first, most significant bit first), the register returns to zero and a status output reports a good check. A software hunt request drops alignment at any time and restarts the search.

Flow control follows these rules. The output `char_valid` rises when a character completes. It then holds `char_data` steady until `char_ready` is seen high at a clock edge. While an offered character is not yet taken, `bit_ready` is low, so the bit source is stalled and no data is lost. A bit transfers on an edge where both `bit_valid` and `bit_ready` are high.

Top module: `sch_hunter`

## Requirements
- R1: After reset, `hunting` is 1 and `char_valid`, `sync_found` and `crc_ok` are 0. In single-pattern mode (`dual_sync`=0, `ext_mode`=0), the block leaves hunt on the accepted bit that completes a match of the last CHAR_W bits against `sync_a`, where the earliest received bit is the most significant. From the next cycle, `hunting` is 0 and `sync_found` is 1 for exactly one cycle.
- R2: In dual-pattern mode (`dual_sync`=1), a match needs `sync_a` followed directly by `sync_b` (2*CHAR_W bits). `sync_a` alone does not end hunt.
- R3: A match is recognised only after enough bits have been accepted since hunt was entered: CHAR_W bits in single-pattern mode, or 2*CHAR_W bits in dual-pattern mode. Bits from before hunt was entered never take part in a match.
- R4: With `ext_mode`=1, pattern matching is disabled. `ext_sync` high at a clock edge while hunting ends hunt and pulses `sync_found`. The first character starts with the next bit accepted after that edge.
- R5: After sync, every CHAR_W accepted bits form one character, with the first bit received as bit CHAR_W-1. The character is presented on `char_data` with `char_valid`=1.
- R6: While `char_valid`=1 and `char_ready`=0, `char_data` and `char_valid` hold steady and `bit_ready` is 0.
- R7: `enter_hunt` high at a clock edge sets `hunting` to 1 and discards any partly assembled character. It takes priority over a match in the same cycle.
- R8: `crc_sel`=0 selects x^16+x^15+x^2+1 (0x8005). `crc_sel`=1 selects x^16+x^12+x^5+1 (0x1021). The register shifts most significant bit first with no final inversion, and it is updated only with bits accepted after sync.
- R9: When sync is declared, the CRC register is loaded with 0xFFFF if `crc_preset_ones`=1, or with 0x0000 otherwise.
- R10: `crc_ok` is 1 exactly when the block is out of hunt and the CRC register is zero. A message followed by its correct CRC therefore gives `crc_ok`=1, and a corrupted CRC gives 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bit_valid | input | 1 | Serial bit offered |
| bit_ready | output | 1 | Block can take a bit |
| bit_in | input | 1 | Serial data bit |
| ext_mode | input | 1 | 1: sync comes from `ext_sync`, not from pattern match |
| ext_sync | input | 1 | External sync strobe |
| dual_sync | input | 1 | 1: two-character sync pattern |
| sync_a | input | CHAR_W | First (or only) sync character |
| sync_b | input | CHAR_W | Second sync character |
| enter_hunt | input | 1 | Force return to hunt |
| crc_sel | input | 1 | 0: CRC-16, 1: CRC-CCITT |
| crc_preset_ones | input | 1 | CRC preset: 1 = all ones, 0 = all zeros |
| char_valid | output | 1 | Character offered |
| char_ready | input | 1 | Consumer takes the character |
| char_data | output | CHAR_W | Assembled character |
| hunting | output | 1 | Block is searching for sync |
| sync_found | output | 1 | One-cycle pulse when sync is declared |
| crc_ok | output | 1 | Out of hunt and CRC register zero |

## Verification
On every cycle, the bound checker enforces these properties:
- the shape of the sync pulse and its relation to `hunting`;
- that characters appear only when out of hunt;
- that the stream stalls under back-pressure;
- that an external strobe ends hunt;
- that a hunt request lands, and that `crc_ok` never shows during hunt.

Only the bench scenarios can show the following:
- that the pattern logic matches the right bit sequences, for single and dual patterns, with the fill guard after a hunt request;
- that characters fall on the right boundaries, including after an external strobe or a discarded partial character;
- that both polynomials and both presets give a zero residue on correct messages and a nonzero one on corrupted messages.

// File: rtl/sch_pkg.sv
package sch_pkg;
  localparam int CRC_W = 16;
  localparam logic [CRC_W-1:0] POLY_CRC16 = 16'h8005;
  localparam logic [CRC_W-1:0] POLY_CCITT = 16'h1021;

  typedef enum logic {
    CRC_KIND_16    = 1'b0,
    CRC_KIND_CCITT = 1'b1
  } crc_kind_e;

  function automatic logic [CRC_W-1:0] pick_poly(input crc_kind_e kind);
    return (kind == CRC_KIND_CCITT) ? POLY_CCITT : POLY_CRC16;
  endfunction
endpackage

// File: rtl/sch_sync_detect.sv
module sch_sync_detect #(
  parameter int CHAR_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clear,
  input  logic              shift_en,
  input  logic              bit_in,
  input  logic              dual,
  input  logic [CHAR_W-1:0] pat_a,
  input  logic [CHAR_W-1:0] pat_b,
  output logic              match
);
  localparam int HW = 2 * CHAR_W;
  localparam int FW = $clog2(HW + 1);
  localparam logic [FW-1:0] FILL_FULL = FW'(HW);
  localparam logic [FW-1:0] FILL_ONE  = FW'(CHAR_W);

  logic [HW-1:0] hist_q, hist_nxt;
  logic [FW-1:0] fill_q, fill_nxt;
  logic          hit_single, hit_dual;

  // Window including the bit being accepted this cycle
  assign hist_nxt = {hist_q[HW-2:0], bit_in};
  assign fill_nxt = (fill_q == FILL_FULL) ? fill_q : fill_q + 1'b1;

  assign hit_single = (fill_nxt >= FILL_ONE)  && (hist_nxt[CHAR_W-1:0] == pat_a);
  assign hit_dual   = (fill_nxt == FILL_FULL) && (hist_nxt == {pat_a, pat_b});
  assign match      = shift_en && (dual ? hit_dual : hit_single);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hist_q <= '0;
      fill_q <= '0;
    end else if (clear) begin
      hist_q <= '0;
      fill_q <= '0;
    end else if (shift_en) begin
      hist_q <= hist_nxt;
      fill_q <= fill_nxt;
    end
  end
endmodule

// File: rtl/sch_char_asm.sv
module sch_char_asm #(
  parameter int CHAR_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              restart,
  input  logic              bit_en,
  input  logic              bit_in,
  input  logic              out_ready,
  output logic              out_valid,
  output logic [CHAR_W-1:0] out_data
);
  localparam int CW = $clog2(CHAR_W);
  localparam logic [CW-1:0] LAST = CW'(CHAR_W - 1);

  logic [CW-1:0]     cnt_q;
  logic [CHAR_W-1:0] sh_q;
  logic              done;

  assign done = bit_en && !restart && (cnt_q == LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      sh_q  <= '0;
    end else if (restart) begin
      cnt_q <= '0;
      sh_q  <= '0;
    end else if (bit_en) begin
      sh_q  <= {sh_q[CHAR_W-2:0], bit_in};
      cnt_q <= done ? '0 : cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_data  <= '0;
    end else if (done) begin
      out_valid <= 1'b1;
      out_data  <= {sh_q[CHAR_W-2:0], bit_in};
    end else if (out_ready) begin
      out_valid <= 1'b0;
    end
  end
endmodule

// File: rtl/sch_crc.sv
module sch_crc
  import sch_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic             preset_ones,
  input  logic             step,
  input  logic             bit_in,
  input  crc_kind_e        kind,
  output logic [CRC_W-1:0] crc
);
  logic [CRC_W-1:0] poly, nxt;
  logic             fb;

  assign poly = pick_poly(kind);
  assign fb   = crc[CRC_W-1] ^ bit_in;

  for (genvar i = 0; i < CRC_W; i++) begin : g_tap
    if (i == 0) begin : g_lsb
      assign nxt[i] = fb & poly[i];
    end else begin : g_mid
      assign nxt[i] = crc[i-1] ^ (fb & poly[i]);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      crc <= '0;
    else if (load)   crc <= preset_ones ? '1 : '0;
    else if (step)   crc <= nxt;
  end
endmodule

// File: rtl/sch_hunter.sv
module sch_hunter
  import sch_pkg::*;
#(
  parameter int CHAR_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bit_valid,
  output logic              bit_ready,
  input  logic              bit_in,
  input  logic              ext_mode,
  input  logic              ext_sync,
  input  logic              dual_sync,
  input  logic [CHAR_W-1:0] sync_a,
  input  logic [CHAR_W-1:0] sync_b,
  input  logic              enter_hunt,
  input  logic              crc_sel,
  input  logic              crc_preset_ones,
  output logic              char_valid,
  input  logic              char_ready,
  output logic [CHAR_W-1:0] char_data,
  output logic              hunting,
  output logic              sync_found,
  output logic              crc_ok
);
  logic             take, pat_match, ext_hit, lock_now, bit_en;
  logic [CRC_W-1:0] crc_q;

  assign bit_ready = !char_valid || char_ready;
  assign take      = bit_valid && bit_ready;
  assign ext_hit   = hunting && ext_mode && ext_sync;
  assign lock_now  = !enter_hunt && (pat_match || ext_hit);
  assign bit_en    = take && !hunting && !enter_hunt;

  sch_sync_detect #(.CHAR_W(CHAR_W)) u_detect (
    .clk      (clk),
    .rst_n    (rst_n),
    .clear    (enter_hunt || !hunting),
    .shift_en (take && hunting && !ext_mode),
    .bit_in   (bit_in),
    .dual     (dual_sync),
    .pat_a    (sync_a),
    .pat_b    (sync_b),
    .match    (pat_match)
  );

  sch_char_asm #(.CHAR_W(CHAR_W)) u_asm (
    .clk       (clk),
    .rst_n     (rst_n),
    .restart   (enter_hunt || lock_now),
    .bit_en    (bit_en),
    .bit_in    (bit_in),
    .out_ready (char_ready),
    .out_valid (char_valid),
    .out_data  (char_data)
  );

  sch_crc u_crc (
    .clk         (clk),
    .rst_n       (rst_n),
    .load        (lock_now),
    .preset_ones (crc_preset_ones),
    .step        (bit_en),
    .bit_in      (bit_in),
    .kind        (crc_kind_e'(crc_sel)),
    .crc         (crc_q)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hunting    <= 1'b1;
      sync_found <= 1'b0;
    end else begin
      sync_found <= lock_now;
      if (enter_hunt)    hunting <= 1'b1;
      else if (lock_now) hunting <= 1'b0;
    end
  end

  assign crc_ok = !hunting && (crc_q == '0);
endmodule

// File: rtl/sch_hunter_chk.sv
module sch_hunter_chk #(
  parameter int CHAR_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              bit_ready,
  input logic              ext_mode,
  input logic              ext_sync,
  input logic              enter_hunt,
  input logic              char_valid,
  input logic              char_ready,
  input logic [CHAR_W-1:0] char_data,
  input logic              hunting,
  input logic              sync_found,
  input logic              crc_ok
);
  // R1: sync pulse lasts one cycle and coincides with leaving hunt
  p_sync_pulse_r1: assert property (@(posedge clk) disable iff (!rst_n)
    sync_found |=> !sync_found);
  p_sync_out_of_hunt_r1: assert property (@(posedge clk) disable iff (!rst_n)
    sync_found |-> !hunting);
  // R4: external strobe ends hunt
  p_ext_lock_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (ext_mode && ext_sync && hunting && !enter_hunt) |=> (!hunting && sync_found));
  // R5: characters only form after sync
  p_char_after_sync_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(char_valid) |-> !$past(hunting));
  // R6: back-pressure holds the character and stalls input
  p_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (char_valid && !char_ready) |=> (char_valid && $stable(char_data)));
  p_stall_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (char_valid && !char_ready) |-> !bit_ready);
  // R7: hunt request lands
  p_enter_hunt_r7: assert property (@(posedge clk) disable iff (!rst_n)
    enter_hunt |=> hunting);
  // R10: no good-check report during hunt
  p_crc_ok_locked_r10: assert property (@(posedge clk) disable iff (!rst_n)
    crc_ok |-> !hunting);
endmodule

bind sch_hunter sch_hunter_chk #(.CHAR_W(CHAR_W)) u_chk (.*);

// File: tb/sch_hunter_tb.sv
`timescale 1ns/1ps
module sch_hunter_tb;
  localparam int W = 8;

  logic clk = 1'b0, rst_n = 1'b0;
  logic bit_valid = 0, bit_in = 0, ext_mode = 0, ext_sync = 0, dual_sync = 0;
  logic [W-1:0] sync_a = '0, sync_b = '0;
  logic enter_hunt = 0, crc_sel = 0, crc_preset_ones = 0, char_ready = 1;
  logic bit_ready, char_valid, hunting, sync_found, crc_ok;
  logic [W-1:0] char_data;

  int n_chk = 0, n_fail = 0;
  logic [W-1:0] exp_q[$];

  always #2.5 clk = ~clk;

  sch_hunter #(.CHAR_W(W)) u_dut (.*);

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  // Scoreboard monitor
  always @(negedge clk) begin
    if (rst_n && char_valid && char_ready) begin
      if (exp_q.size() == 0) check(0, "R5 unexpected char", char_data, 0);
      else begin
        logic [W-1:0] e;
        e = exp_q.pop_front();
        check(char_data == e, "R5 char data", char_data, e);
      end
    end
  end

  task automatic send_bit(input logic b);
    @(negedge clk);
    bit_valid = 1; bit_in = b;
    while (!bit_ready) @(negedge clk);
    @(negedge clk);
    bit_valid = 0;
  endtask

  task automatic send_byte(input logic [W-1:0] v);
    for (int i = W-1; i >= 0; i--) send_bit(v[i]);
  endtask

  task automatic pulse_hunt();
    @(negedge clk); enter_hunt = 1;
    @(negedge clk); enter_hunt = 0;
  endtask

  function automatic logic [15:0] crc_upd(input logic [15:0] c, input logic [7:0] v,
                                          input logic ccitt);
    logic [15:0] p;
    p = ccitt ? 16'h1021 : 16'h8005;
    for (int i = 7; i >= 0; i--) begin
      logic fb;
      fb = c[15] ^ v[i];
      c = {c[14:0], 1'b0};
      if (fb) c = c ^ p;
    end
    return c;
  endfunction

  task automatic crc_case(input logic ccitt, input logic ones, input logic [7:0] d0,
                          input logic [7:0] d1, input logic [7:0] d2, input logic corrupt,
                          input string tag);
    logic [15:0] c;
    pulse_hunt();
    crc_sel = ccitt; crc_preset_ones = ones; dual_sync = 0; sync_a = 8'h16;
    send_byte(8'h16);
    check(hunting == 0, {tag, " lock"}, hunting, 0);
    c = ones ? 16'hFFFF : 16'h0000;
    c = crc_upd(c, d0, ccitt); c = crc_upd(c, d1, ccitt); c = crc_upd(c, d2, ccitt);
    if (corrupt) c = c ^ 16'h0004;
    exp_q.push_back(d0); exp_q.push_back(d1); exp_q.push_back(d2);
    exp_q.push_back(c[15:8]); exp_q.push_back(c[7:0]);
    send_byte(d0); send_byte(d1); send_byte(d2);
    send_byte(c[15:8]); send_byte(c[7:0]);
    check(crc_ok == !corrupt, {tag, " crc_ok"}, crc_ok, !corrupt);
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    check(0, "watchdog", 0, 1);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    check(hunting == 1 && char_valid == 0 && sync_found == 0 && crc_ok == 0,
          "R1 reset", {hunting, char_valid, sync_found, crc_ok}, 4'b1000);
    rst_n = 1;
    @(negedge clk);

    // R1 single pattern, preceded by noise
    sync_a = 8'h16;
    send_byte(8'hFF);
    check(hunting == 1, "R1 noise keeps hunt", hunting, 1);
    send_byte(8'h16);
    check(hunting == 0 && sync_found == 1, "R1 lock pulse", {hunting, sync_found}, 2'b01);
    @(negedge clk);
    check(sync_found == 0, "R1 pulse one cycle", sync_found, 0);
    exp_q.push_back(8'h41); send_byte(8'h41);
    exp_q.push_back(8'hB2); send_byte(8'hB2);

    // R10 crc_ok low in hunt
    pulse_hunt();
    check(hunting == 1 && crc_ok == 0, "R10 hunt crc_ok", {hunting, crc_ok}, 2'b10);

    // R3 fill guard with all-zero pattern
    sync_a = 8'h00;
    for (int i = 0; i < W-1; i++) send_bit(1'b0);
    check(hunting == 1, "R3 short run", hunting, 1);
    send_bit(1'b0);
    check(hunting == 0, "R3 full run locks", hunting, 0);

    // R2 dual pattern
    pulse_hunt();
    dual_sync = 1; sync_a = 8'h96; sync_b = 8'h3C;
    send_byte(8'h96);
    check(hunting == 1, "R2 first char alone", hunting, 1);
    send_byte(8'h00);
    check(hunting == 1, "R2 wrong second", hunting, 1);
    send_byte(8'h96); send_byte(8'h3C);
    check(hunting == 0 && sync_found == 1, "R2 lock", {hunting, sync_found}, 2'b01);
    exp_q.push_back(8'h5A); send_byte(8'h5A);
    dual_sync = 0;

    // R4 external sync
    pulse_hunt();
    ext_mode = 1; sync_a = 8'h16;
    send_byte(8'h16);
    check(hunting == 1, "R4 pattern ignored", hunting, 1);
    @(negedge clk); ext_sync = 1;
    @(negedge clk); ext_sync = 0;
    check(hunting == 0 && sync_found == 1, "R4 ext lock", {hunting, sync_found}, 2'b01);
    exp_q.push_back(8'hA5); send_byte(8'hA5);
    ext_mode = 0;

    // R7 partial char discarded
    pulse_hunt();
    send_byte(8'h16);
    send_bit(1); send_bit(1); send_bit(0);
    pulse_hunt();
    check(hunting == 1 && char_valid == 0, "R7 hunt, no char", {hunting, char_valid}, 2'b10);
    send_byte(8'h16);
    exp_q.push_back(8'hC3); send_byte(8'hC3);

    // R7 priority over match in same cycle
    pulse_hunt();
    for (int i = W-1; i >= 1; i--) send_bit(sync_a[i]);
    @(negedge clk); bit_valid = 1; bit_in = sync_a[0]; enter_hunt = 1;
    @(negedge clk); bit_valid = 0; enter_hunt = 0;
    check(hunting == 1 && sync_found == 0, "R7 priority", {hunting, sync_found}, 2'b10);

    // R6 back-pressure
    pulse_hunt();
    send_byte(8'h16);
    char_ready = 0;
    send_byte(8'h7E);
    @(negedge clk); bit_valid = 1; bit_in = 1;
    check(bit_ready == 0, "R6 stall", bit_ready, 0);
    repeat (3) @(negedge clk);
    check(char_valid == 1 && char_data == 8'h7E, "R6 held", char_data, 8'h7E);
    bit_valid = 0;
    exp_q.push_back(8'h7E);
    char_ready = 1;
    @(negedge clk);
    @(negedge clk);
    check(char_valid == 0 && bit_ready == 1, "R6 released", {char_valid, bit_ready}, 2'b01);

    // R8 R9 R10 CRC cases
    crc_case(0, 0, 8'h31, 8'h32, 8'h33, 0, "R8 crc16 zero");
    crc_case(1, 1, 8'hC0, 8'hFF, 8'hEE, 0, "R9 ccitt ones");
    crc_case(0, 1, 8'h12, 8'h34, 8'h56, 0, "R9 crc16 ones");
    crc_case(1, 0, 8'hAB, 8'hCD, 8'hEF, 1, "R10 corrupt");

    repeat (4) @(negedge clk);
    check(exp_q.size() == 0, "R5 all chars seen", exp_q.size(), 0);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule